// File: doc/BRIEF.md
# Programmable Divide-by-N Down-Counter

This block divides its clock by a programmed ratio N. For every N clock cycles it produces an output pulse one clock wide. N comes from a 16-bit jam word that is split across three parts of a down-counter:

- A prescaler with a modulus of 2, 4, 5, 8 or 10, chosen by a 3-bit mode input.
- Three cascaded decimal-weighted digits.
- A last section made of the jam-nibble bits that the prescaler leaves unused.

The prescaler's modulus sets the place value of everything above it. Each digit may be preset to any value from 0 to 15, which extends the usable range. A hold input freezes the output while the counter keeps running. A dedicated mode code forces the counter into a master-preset state. In that state the counter is loaded from the jam word and held there until a counting mode is selected. Typical uses are channel-step division in a frequency synthesizer, fixed division and long time-outs.

Top module: `divn_counter`

## Requirements
- R1: `mode_sel` is read as {a,b,c} with a = bit 2. The codes are:
  - 111 selects ÷2.
  - 011 selects ÷4.
  - 101 selects ÷5.
  - 001 selects ÷8.
  - 110 and 010 select ÷10.
  - 000 and 100 select master preset.
- R2: The jam word is laid out as follows:
  - `jam[15:12]` is the hundreds digit, `jam[11:8]` the tens digit and `jam[7:4]` the units digit.
  - `jam[3:0]` is shared between the prescaler and the last section. The prescaler takes its low 1, 2, 3, 3 or 4 bits in ÷2, ÷4, ÷5, ÷8 or ÷10 respectively.
  - The remaining upper bits of `jam[3:0]` form the last section, weighted 1000.
- R3: The ratio is N = P + M×(1000×L + 100×H + 10×T + U), where M is the modulus, P the prescaler field, L the last section and H, T, U the digits. For N ≥ 3, `div_out` pulses once every N clock cycles.
- R4: Each pulse on `div_out` is exactly one clock cycle wide.
- R5: A digit preset above 9 counts with its full value at its place value. A digit that borrows from 0 wraps to 9.
- R6: While master preset is selected, `div_out` stays low and the counter reloads from `jam` on every edge. After a counting mode is selected, the first pulse appears after the N-th clock edge.
- R7: While `out_hold` is high, `div_out` keeps its value.
- R8: While `out_hold` is high the counter keeps counting, so pulse timing after release keeps its original phase.
- R9: A synchronous reset clears `div_out` and loads the counter from `jam`. The first pulse then appears N edges after reset is released.
- R10: In ÷8 mode with every jam bit set, N = 21327.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock to be divided |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 3 | Modulus / master-preset select {a,b,c} |
| jam | input | 16 | Preset word for all sections |
| out_hold | input | 1 | Freezes `div_out` when high |
| div_out | output | 1 | One-cycle pulse every N clocks |

## Verification
Any fault in an internal digit, borrow chain or field mask changes the ratio, so the error shows as a wrong pulse spacing. It is visible at the first pulse after release from preset, at most N cycles later. A faulty reload is visible in the interval that follows a pulse. Field-split errors only appear in modes that have a last section, so each mode is released from preset with a known jam value. The measured gaps are then compared with the ratio computed in the bench.

// File: rtl/divn_pkg.sv
package divn_pkg;

    typedef enum logic [2:0] {
        MODE_PRESET,
        MODE_DIV2,
        MODE_DIV4,
        MODE_DIV5,
        MODE_DIV8,
        MODE_DIV10
    } mode_e;

    // prescaler field mask and highest prescaler value for a mode
    typedef struct packed {
        logic [3:0] mask;
        logic [3:0] top;
    } pre_info_t;

    function automatic mode_e decode_mode(input logic [2:0] sel);
        mode_e m;
        case (sel)
            3'b111:         m = MODE_DIV2;
            3'b011:         m = MODE_DIV4;
            3'b101:         m = MODE_DIV5;
            3'b001:         m = MODE_DIV8;
            3'b110, 3'b010: m = MODE_DIV10;
            default:        m = MODE_PRESET;
        endcase
        return m;
    endfunction

    function automatic pre_info_t mode_info(input mode_e m);
        pre_info_t r;
        case (m)
            MODE_DIV2: r = '{mask: 4'h1, top: 4'd1};
            MODE_DIV4: r = '{mask: 4'h3, top: 4'd3};
            MODE_DIV5: r = '{mask: 4'h7, top: 4'd4};
            MODE_DIV8: r = '{mask: 4'h7, top: 4'd7};
            default:   r = '{mask: 4'hF, top: 4'd9};
        endcase
        return r;
    endfunction

endpackage

// File: rtl/divn_mode_dec.sv
module divn_mode_dec
    import divn_pkg::*;
(
    input  logic [2:0] mode_sel,
    output logic       counting,
    output logic [3:0] pre_mask,
    output logic [3:0] pre_top
);
    mode_e     mode;
    pre_info_t info;

    always_comb begin
        mode     = decode_mode(mode_sel);
        info     = mode_info(mode);
        counting = (mode != MODE_PRESET);
        pre_mask = info.mask;
        pre_top  = info.top;
    end
endmodule

// File: rtl/divn_digit.sv
module divn_digit #(
    parameter int W   = 4,
    parameter int TOP = 9
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic [W-1:0] q,
    output logic         zero
);
    localparam logic [W-1:0] WRAP = W'(TOP);

    assign zero = (q == '0);

    always_ff @(posedge clk) begin
        if (rst || load)
            q <= load_val;
        else if (dec)
            q <= zero ? WRAP : q - W'(1);
    end

    AST_DIGIT_WRAP: assert property (@(posedge clk) disable iff (rst)
        (dec && !load && zero) |=> (q == WRAP)); // R5
endmodule

// File: rtl/divn_prescale.sv
module divn_prescale #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         step,
    input  logic         upper_zero,
    input  logic [W-1:0] mask,
    input  logic [W-1:0] top,
    output logic [W-1:0] q,
    output logic         borrow
);
    logic [W-1:0] field;
    logic [W-1:0] upper;
    logic         field_zero;

    assign field      = q & mask;
    assign upper      = q & ~mask;
    assign field_zero = (field == '0);
    assign borrow     = step && field_zero;

    always_ff @(posedge clk) begin
        if (rst || load)
            q <= load_val;
        else if (step) begin
            if (!field_zero)
                q <= q - W'(1);
            else if (upper_zero)
                q <= (upper - (mask + W'(1))) | top;
            else
                q <= upper | top;
        end
    end

    AST_FIELD_WRAP: assert property (@(posedge clk) disable iff (rst)
        (step && !load && field_zero) |=> ((q & $past(mask)) == $past(top))); // R3
endmodule

// File: rtl/divn_out_latch.sv
module divn_out_latch (
    input  logic clk,
    input  logic rst,
    input  logic hold,
    input  logic tc,
    output logic pulse
);
    always_ff @(posedge clk) begin
        if (rst)
            pulse <= 1'b0;
        else if (!hold)
            pulse <= tc;
    end

    AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (rst)
        hold |=> $stable(pulse)); // R7
endmodule

// File: rtl/divn_counter.sv
module divn_counter #(
    parameter int NIB_W  = 4,
    parameter int DIGITS = 3,
    parameter int JAM_W  = NIB_W * (DIGITS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [2:0]       mode_sel,
    input  logic [JAM_W-1:0] jam,
    input  logic             out_hold,
    output logic             div_out
);
    localparam int DIGIT_TOP = 9;

    logic              counting;
    logic [NIB_W-1:0]  pre_mask;
    logic [NIB_W-1:0]  pre_top;
    logic [NIB_W-1:0]  pre_q;
    logic              pre_borrow;
    logic              tc;
    logic              load_all;
    logic              step;
    logic              upper_zero;
    logic [DIGITS-1:0] dig_zero;
    logic [DIGITS:0]   chain;

    divn_mode_dec i_dec (
        .mode_sel (mode_sel),
        .counting (counting),
        .pre_mask (pre_mask),
        .pre_top  (pre_top)
    );

    assign upper_zero = &dig_zero;
    assign tc         = counting && (pre_q == NIB_W'(1)) && upper_zero;
    assign load_all   = !counting || tc;
    assign step       = counting && !tc;

    divn_prescale #(.W(NIB_W)) i_pre (
        .clk        (clk),
        .rst        (rst),
        .load       (load_all),
        .load_val   (jam[NIB_W-1:0]),
        .step       (step),
        .upper_zero (upper_zero),
        .mask       (pre_mask),
        .top        (pre_top),
        .q          (pre_q),
        .borrow     (pre_borrow)
    );

    assign chain[0] = pre_borrow;

    for (genvar i = 0; i < DIGITS; i++) begin : g_digit
        logic [NIB_W-1:0] q;
        assign chain[i+1] = chain[i] && dig_zero[i];
        divn_digit #(.W(NIB_W), .TOP(DIGIT_TOP)) i_digit (
            .clk      (clk),
            .rst      (rst),
            .load     (load_all),
            .load_val (jam[NIB_W*(i+1) +: NIB_W]),
            .dec      (chain[i]),
            .q        (q),
            .zero     (dig_zero[i])
        );
    end

    divn_out_latch i_out (
        .clk   (clk),
        .rst   (rst),
        .hold  (out_hold),
        .tc    (tc),
        .pulse (div_out)
    );

    AST_PRESET_LOAD: assert property (@(posedge clk) disable iff (rst)
        !counting |=> (pre_q == $past(jam[NIB_W-1:0]))); // R6

    AST_PRESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!counting && !out_hold) |=> !div_out); // R6

    AST_TC_RELOAD: assert property (@(posedge clk) disable iff (rst)
        tc |=> (pre_q == $past(jam[NIB_W-1:0]) && !upper_zero || pre_q == $past(jam[NIB_W-1:0]))); // R3

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (div_out && !out_hold && $past(!out_hold) && counting) |=> !div_out); // R4
endmodule

// File: tb/test_divn_counter.sv
`timescale 1ns/1ps
module test_divn_counter;
    logic        clk = 1'b0;
    logic        rst;
    logic [2:0]  mode_sel;
    logic [15:0] jam;
    logic        out_hold;
    logic        div_out;

    int compared   = 0;
    int mismatched = 0;
    bit done       = 1'b0;

    always #10 clk = ~clk;

    divn_counter i_divn_counter (
        .clk      (clk),
        .rst      (rst),
        .mode_sel (mode_sel),
        .jam      (jam),
        .out_hold (out_hold),
        .div_out  (div_out)
    );

    function automatic int calc_n(input logic [2:0] s, input logic [15:0] j);
        int m, fw, first, last;
        case (s)
            3'b111:  begin m = 2;  fw = 1; end
            3'b011:  begin m = 4;  fw = 2; end
            3'b101:  begin m = 5;  fw = 3; end
            3'b001:  begin m = 8;  fw = 3; end
            default: begin m = 10; fw = 4; end
        endcase
        first = int'(j[3:0]) & ((1 << fw) - 1);
        last  = int'(j[3:0]) >> fw;
        return first + m * (1000 * last + 100 * int'(j[15:12]) + 10 * int'(j[11:8]) + int'(j[7:4]));
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_pulse(output int k, input int limit);
        k = 0;
        do begin
            @(negedge clk);
            k++;
        end while (!div_out && k < limit);
    endtask

    task automatic run_case(input logic [2:0] s, input logic [15:0] j,
                            input string tag, input bit do_period);
        int n, k;
        n = calc_n(s, j);
        mode_sel = 3'b000;
        jam      = j;
        repeat (3) @(negedge clk);
        check(div_out == 1'b0, {"R6 quiet in preset ", tag}, int'(div_out), 0);
        mode_sel = s;
        wait_pulse(k, n + 10);
        check(k == n, {"R6 first pulse ", tag}, k, n);
        if (do_period) begin
            @(negedge clk);
            check(div_out == 1'b0, {"R4 width ", tag}, int'(div_out), 0);
            k = 1;
            while (!div_out && k < n + 10) begin
                @(negedge clk);
                k++;
            end
            check(k == n, {"R3 period ", tag}, k, n);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            mismatched++;
            compared++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        logic [2:0] codes [6];
        int n, k;
        logic [2:0] s;
        logic [15:0] j;
        codes[0] = 3'b111; codes[1] = 3'b011; codes[2] = 3'b101;
        codes[3] = 3'b001; codes[4] = 3'b110; codes[5] = 3'b010;
        void'($urandom(1234));

        rst = 1'b1; mode_sel = 3'b111; jam = 16'h0021; out_hold = 1'b0;
        repeat (3) @(negedge clk);
        check(div_out == 1'b0, "R9 reset output", int'(div_out), 0);
        rst = 1'b0;
        wait_pulse(k, 20);
        check(k == 5, "R9 first pulse after reset", k, 5);

        run_case(3'b111, 16'h0011, "R3 min N ÷2", 1'b1);
        run_case(3'b110, 16'h00F3, "R5 digit 15", 1'b1);
        run_case(3'b110, 16'h0100, "R5 borrow wrap", 1'b1);
        run_case(3'b010, 16'h0027, "R1 alt ÷10 code", 1'b1);
        run_case(3'b101, 16'h0009, "R2 last section ÷5", 1'b1);
        run_case(3'b011, 16'h000E, "R2 last section ÷4", 1'b0);
        run_case(3'b001, 16'hFFFF, "R10 max ÷8", 1'b0);

        for (int t = 0; t < 8; t++) begin
            s = codes[$urandom % 6];
            do begin
                j = {4'h0, 4'($urandom), 4'($urandom), 4'($urandom)};
                n = calc_n(s, j);
            end while (n < 3 || n > 2000);
            run_case(s, j, "R1 random", 1'b1);
        end

        // hold while low: ÷4, jam 0x0012 -> N = 6
        mode_sel = 3'b000; jam = 16'h0012;
        repeat (2) @(negedge clk);
        mode_sel = 3'b011;
        wait_pulse(k, 20);
        @(negedge clk);
        out_hold = 1'b1;
        for (int i = 2; i < 18; i++) begin
            @(negedge clk);
            check(div_out == 1'b0, "R7 held low", int'(div_out), 0);
        end
        out_hold = 1'b0;
        @(negedge clk);
        check(div_out == 1'b1, "R8 phase kept", int'(div_out), 1);
        @(negedge clk);
        check(div_out == 1'b0, "R4 width after hold", int'(div_out), 0);

        // hold while high
        wait_pulse(k, 20);
        out_hold = 1'b1;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            check(div_out == 1'b1, "R7 held high", int'(div_out), 1);
        end
        out_hold = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule